// File: doc/BRIEF.md
# Transceiver Power State Controller

This block sequences the low-power states of a radio transceiver. It holds three states: power-on, idle with the clock running, and sleep. It reacts to a sleep-request pin, an active-low reset pin and writes from a register port. From these it drives a gate for the master clock output, a strobe that wipes the frame buffer and crypto key storage, a wake-done interrupt, and an enable for the input pull resistors.

After power-up the block waits in power-on until software writes an off or force-off command. It then enters idle. From idle, a high level on the sleep-request pin puts the block to sleep. Sleep is entered at once when the clock output is off or set to one of the two slow rates. For the fast rates, entry waits 35 cycles of the output clock, so the host receives its final clock edges before the clock stops. A divider model inside the block produces one enable strobe per output-clock period, and the wait is counted on those strobes. The block leaves sleep for idle when the sleep-request pin drops or when the reset pin is pulled low. A reset-pin pulse restores the register defaults but keeps the clock-control field.

Top module: `radio_pwr_ctl`

## Requirements
- R1: While and after `rst` is high, the outputs take these values: `state_o` is 5'h00 (power-on), `pull_en` is 1 and `clkout_gate` is 1, because the clock code defaults to 1. `irq_wake` and `buf_clear` are 0.
- R2: Power-on moves to idle (`state_o` 5'h08) on the edge that takes a write to address 0x02 whose bits 4:0 hold 5'h08 (off) or 5'h03 (force off). Any other value, and any other address, leaves the block in power-on.
- R3: The move from power-on to idle raises `irq_wake` for exactly one cycle, together with the new state. This happens only when bit 4 of the mask register (address 0x0E) is set. The mask is 0 after reset.
- R4: `pull_en` is 1 exactly while `state_o` is power-on.
- R5: Sleep (`state_o` 5'h0F) is entered only from idle. A high sleep-request level in power-on has no effect.
- R6: The clock-control field is bits 2:0 of address 0x03. When the code is 0 (off), 5 (slow rate A) or 6 (slow rate B), a high `sleep_req` in idle enters sleep on the first edge that samples it.
- R7: For the fast codes c (1, 2, 3, 4, 7), the divider model strobes once every c cycles. Counting the edge that first samples `sleep_req` high in idle as edge 0, sleep is entered on edge 35*c. `clkout_gate` falls on that same edge.
- R8: If `sleep_req` falls before the count ends, the block stays in idle and the clock stays on. A later request starts a fresh full count.
- R9: `clkout_gate` is 1 exactly when the clock code is nonzero and the state is not sleep. A code write takes effect on the edge that takes the write.
- R10: `sleep_req` low in sleep returns the block to idle on the next edge. `buf_clear` pulses for one cycle together with that state change, and the clock code is kept.
- R11: `rst_pin_n` low in sleep returns the block to idle on the next edge with a one-cycle `buf_clear`. The clock code keeps its value, so the gate and the entry delay are unchanged afterwards. The reset pin takes priority over `sleep_req`.
- R12: `rst_pin_n` low, in any state, restores the mask to 0 and ignores a write taken in that cycle. The state is kept, except that sleep moves to idle.
- R13: Every register write taken while in sleep is ignored, including commands and clock-code writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| sleep_req | input | 1 | Sleep-request pin, level sensitive |
| rst_pin_n | input | 1 | Active-low reset pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| state_o | output | 5 | Current state code |
| clkout_gate | output | 1 | Enable for the master clock output |
| buf_clear | output | 1 | One-cycle wipe of frame buffer and crypto storage |
| irq_wake | output | 1 | One-cycle wake-done interrupt |
| pull_en | output | 1 | Input pull configuration enable |

## Verification
The bench sweeps all eight clock codes. For each code it samples the state one edge before the expected sleep entry and again on that edge. A design that counts from the wrong edge, or uses the wrong divider period, is early or late by at least one cycle. A design that wrongly delays the off and slow codes stays in idle where sleep is expected. The bench also aborts a countdown part way through and then restarts it; a counter that is not cleared on the restart enters sleep too soon. Inside sleep it writes a code of 0 and a command. A design that accepts writes in sleep would then leave the clock gated after wake or move to another state. A reset-pin wake followed by a second timed sleep shows whether the clock field survived the reset.

// File: rtl/radio_pwr_pkg.sv
package radio_pwr_pkg;

  localparam int CK_W = 3;

  typedef enum logic [4:0] {
    PS_PWRON = 5'h00,
    PS_IDLE  = 5'h08,
    PS_SLEEP = 5'h0F
  } pwr_state_e;

  localparam logic [4:0] CMD_OFF       = 5'h08;
  localparam logic [4:0] CMD_FORCE_OFF = 5'h03;

  localparam logic [CK_W-1:0] CK_OFF     = 3'd0;
  localparam logic [CK_W-1:0] CK_DEFAULT = 3'd1;
  localparam logic [CK_W-1:0] CK_SLOW_A  = 3'd5;
  localparam logic [CK_W-1:0] CK_SLOW_B  = 3'd6;

  function automatic logic ck_is_fast(input logic [CK_W-1:0] code);
    return (code != CK_OFF) && (code != CK_SLOW_A) && (code != CK_SLOW_B);
  endfunction

endpackage

// File: rtl/pwr_ctl_regs.sv
module pwr_ctl_regs
  import radio_pwr_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int CLK_ADDR  = 3,
  parameter int MASK_ADDR = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic              wr_blocked,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CK_W-1:0]   clk_code,
  output logic [CK_W-1:0]   clk_code_nxt,
  output logic [DATA_W-1:0] irq_mask
);

  localparam logic [ADDR_W-1:0] CLK_A  = ADDR_W'(CLK_ADDR);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);

  logic              wr_ok;
  logic [DATA_W-1:0] mask_nxt;

  assign wr_ok = wr_en && !wr_blocked && !soft_rst;

  always_comb begin
    clk_code_nxt = clk_code;
    mask_nxt     = irq_mask;
    if (wr_ok && wr_addr == CLK_A)
      clk_code_nxt = wr_data[CK_W-1:0];
    if (soft_rst)
      mask_nxt = '0;
    else if (wr_ok && wr_addr == MASK_A)
      mask_nxt = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_code <= CK_DEFAULT;
      irq_mask <= '0;
    end else begin
      clk_code <= clk_code_nxt;
      irq_mask <= mask_nxt;
    end
  end

endmodule

// File: rtl/clkout_div.sv
module clkout_div
  import radio_pwr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic [CK_W-1:0] code,
  output logic            strobe
);

  logic [CK_W-1:0] cnt;
  logic [CK_W-1:0] lim;

  assign lim    = code - 1'b1;
  assign strobe = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt <= '0;
    else if (strobe)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sleep_entry_timer.sv
module sleep_entry_timer #(
  parameter int DELAY = 35
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic hold,
  input  logic strobe,
  output logic pending,
  output logic done
);

  localparam int CNT_W = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

  logic [CNT_W-1:0] cnt;

  assign done = pending && hold && strobe && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      pending <= 1'b1;
      cnt     <= '0;
    end else if (pending) begin
      if (!hold || done)
        pending <= 1'b0;
      else if (strobe)
        cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/radio_pwr_ctl.sv
module radio_pwr_ctl
  import radio_pwr_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int CMD_ADDR    = 2,
  parameter int CLK_ADDR    = 3,
  parameter int MASK_ADDR   = 14,
  parameter int WAKE_BIT    = 4,
  parameter int SLEEP_DELAY = 35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req,
  input  logic              rst_pin_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [4:0]        state_o,
  output logic              clkout_gate,
  output logic              buf_clear,
  output logic              irq_wake,
  output logic              pull_en
);

  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_ADDR);

  pwr_state_e        st, st_nxt;
  logic [CK_W-1:0]   clk_code, clk_code_nxt;
  logic [DATA_W-1:0] irq_mask;
  logic              soft_rst, wr_blocked, cmd_hit;
  logic              start, strobe, pending, done;
  logic              clr_nxt, irq_nxt;

  assign soft_rst   = !rst_pin_n;
  assign wr_blocked = (st == PS_SLEEP);
  assign cmd_hit    = wr_en && (wr_addr == CMD_A) &&
                      ((wr_data[4:0] == CMD_OFF) || (wr_data[4:0] == CMD_FORCE_OFF));

  pwr_ctl_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CLK_ADDR (CLK_ADDR),
    .MASK_ADDR(MASK_ADDR)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .soft_rst    (soft_rst),
    .wr_en       (wr_en),
    .wr_blocked  (wr_blocked),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .clk_code    (clk_code),
    .clk_code_nxt(clk_code_nxt),
    .irq_mask    (irq_mask)
  );

  clkout_div u_div (
    .clk    (clk),
    .rst    (rst),
    .restart(start),
    .code   (clk_code),
    .strobe (strobe)
  );

  sleep_entry_timer #(
    .DELAY(SLEEP_DELAY)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .hold   (sleep_req && rst_pin_n),
    .strobe (strobe),
    .pending(pending),
    .done   (done)
  );

  always_comb begin
    st_nxt  = st;
    start   = 1'b0;
    clr_nxt = 1'b0;
    irq_nxt = 1'b0;
    unique case (st)
      PS_PWRON: begin
        if (rst_pin_n && cmd_hit) begin
          st_nxt  = PS_IDLE;
          irq_nxt = irq_mask[WAKE_BIT];
        end
      end
      PS_IDLE: begin
        if (done)
          st_nxt = PS_SLEEP;
        else if (rst_pin_n && sleep_req && !pending) begin
          if (ck_is_fast(clk_code))
            start = 1'b1;
          else
            st_nxt = PS_SLEEP;
        end
      end
      PS_SLEEP: begin
        if (!rst_pin_n || !sleep_req) begin
          st_nxt  = PS_IDLE;
          clr_nxt = 1'b1;
        end
      end
      default: st_nxt = PS_PWRON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= PS_PWRON;
      clkout_gate <= 1'b1;
      pull_en     <= 1'b1;
      buf_clear   <= 1'b0;
      irq_wake    <= 1'b0;
    end else begin
      st          <= st_nxt;
      clkout_gate <= (clk_code_nxt != CK_OFF) && (st_nxt != PS_SLEEP);
      pull_en     <= (st_nxt == PS_PWRON);
      buf_clear   <= clr_nxt;
      irq_wake    <= irq_nxt;
    end
  end

  assign state_o = st;

endmodule

// File: rtl/radio_pwr_ctl_chk.sv
module radio_pwr_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       sleep_req,
  input logic       rst_pin_n,
  input logic [4:0] state_o,
  input logic       clkout_gate,
  input logic       buf_clear,
  input logic       irq_wake,
  input logic       pull_en
);

  localparam logic [4:0] S_ON = 5'h00;
  localparam logic [4:0] S_ID = 5'h08;
  localparam logic [4:0] S_SL = 5'h0F;

  a_r5_sleep_from_idle: assert property (@(posedge clk) disable iff (rst)
    (state_o == S_SL && $past(state_o) != S_SL) |-> $past(state_o) == S_ID);

  a_r9_gate_off_in_sleep: assert property (@(posedge clk) disable iff (rst)
    state_o == S_SL |-> !clkout_gate);

  a_r4_pull_in_poweron: assert property (@(posedge clk) disable iff (rst)
    pull_en == (state_o == S_ON));

  a_r3_irq_on_wake: assert property (@(posedge clk) disable iff (rst)
    irq_wake |-> (state_o == S_ID && $past(state_o) == S_ON));

  a_r10_clear_on_exit: assert property (@(posedge clk) disable iff (rst)
    buf_clear |-> ($past(state_o) == S_SL && state_o == S_ID));

  a_r10_exit_on_low: assert property (@(posedge clk) disable iff (rst)
    ($past(state_o) == S_SL && !$past(sleep_req)) |-> (state_o == S_ID && buf_clear));

  a_r13_sleep_holds: assert property (@(posedge clk) disable iff (rst)
    ($past(state_o) == S_SL && $past(sleep_req) && $past(rst_pin_n)) |-> state_o == S_SL);

endmodule

bind radio_pwr_ctl radio_pwr_ctl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sleep_req  (sleep_req),
  .rst_pin_n  (rst_pin_n),
  .state_o    (state_o),
  .clkout_gate(clkout_gate),
  .buf_clear  (buf_clear),
  .irq_wake   (irq_wake),
  .pull_en    (pull_en)
);

// File: tb/radio_pwr_ctl_bench.sv
`timescale 1ns/1ps
module radio_pwr_ctl_bench;

  localparam logic [4:0] S_ON = 5'h00;
  localparam logic [4:0] S_ID = 5'h08;
  localparam logic [4:0] S_SL = 5'h0F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_req = 1'b0;
  logic       rst_pin_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] state_o;
  logic       clkout_gate, buf_clear, irq_wake, pull_en;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  radio_pwr_ctl u_radio_pwr_ctl (
    .clk        (clk),
    .rst        (rst),
    .sleep_req  (sleep_req),
    .rst_pin_n  (rst_pin_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .state_o    (state_o),
    .clkout_gate(clkout_gate),
    .buf_clear  (buf_clear),
    .irq_wake   (irq_wake),
    .pull_en    (pull_en)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic por();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  function automatic bit fast(input int c);
    return (c != 0) && (c != 5) && (c != 6);
  endfunction

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    por();
    // R1 reset values
    chk(state_o, S_ON, "R1 state");
    chk(pull_en, 1, "R1 pull");
    chk(clkout_gate, 1, "R1 gate");
    chk(irq_wake, 0, "R1 irq");
    chk(buf_clear, 0, "R1 clear");

    // R5 sleep request ignored in power-on
    sleep_req = 1'b1;
    step(3);
    chk(state_o, S_ON, "R5 no sleep from poweron");
    sleep_req = 1'b0;

    // R2 wrong value / wrong address
    wr(6'h02, 8'h05);
    chk(state_o, S_ON, "R2 bad cmd value");
    wr(6'h04, 8'h08);
    chk(state_o, S_ON, "R2 bad cmd address");

    // R12 reset pin clears mask
    wr(6'h0E, 8'h10);
    rst_pin_n = 1'b0;
    step();
    rst_pin_n = 1'b1;
    chk(state_o, S_ON, "R12 state kept");
    wr(6'h02, 8'h08);
    chk(state_o, S_ID, "R2 off cmd");
    chk(irq_wake, 0, "R12 mask restored");
    chk(pull_en, 0, "R4 pull off in idle");

    // R3 wake interrupt with mask set
    por();
    wr(6'h0E, 8'h10);
    wr(6'h02, 8'h03);
    chk(state_o, S_ID, "R2 force off cmd");
    chk(irq_wake, 1, "R3 irq raised");
    step();
    chk(irq_wake, 0, "R3 irq one cycle");

    // R6 R7 R9 R10 R13 sweep of clock codes
    for (int c = 0; c < 8; c++) begin
      wr(6'h03, 8'(c));
      chk(clkout_gate, (c != 0), "R9 gate follows code");
      sleep_req = 1'b1;
      if (!fast(c)) begin
        step();
        chk(state_o, S_SL, "R6 immediate sleep");
      end else begin
        step(35 * c);
        chk(state_o, S_ID, "R7 idle one edge early");
        chk(clkout_gate, 1, "R7 gate on before entry");
        step();
        chk(state_o, S_SL, "R7 sleep at 35 periods");
      end
      chk(clkout_gate, 0, "R9 gate off in sleep");
      wr(6'h03, 8'h00);
      wr(6'h02, 8'h03);
      chk(state_o, S_SL, "R13 writes ignored in sleep");
      sleep_req = 1'b0;
      step();
      chk(state_o, S_ID, "R10 wake to idle");
      chk(buf_clear, 1, "R10 clear strobe");
      chk(clkout_gate, (c != 0), "R13 code kept over sleep");
      step();
      chk(buf_clear, 0, "R10 clear one cycle");
    end

    // R8 abort then fresh count
    wr(6'h03, 8'h02);
    sleep_req = 1'b1;
    step(30);
    sleep_req = 1'b0;
    step(100);
    chk(state_o, S_ID, "R8 abort stays idle");
    chk(clkout_gate, 1, "R8 clock stays on");
    sleep_req = 1'b1;
    step(70);
    chk(state_o, S_ID, "R8 fresh count not early");
    step();
    chk(state_o, S_SL, "R8 fresh count completes");

    // R11 reset pin in sleep keeps clock code
    sleep_req = 1'b0;
    step(2);
    wr(6'h03, 8'h03);
    sleep_req = 1'b1;
    step(106);
    chk(state_o, S_SL, "R11 setup sleep");
    rst_pin_n = 1'b0;
    step();
    chk(state_o, S_ID, "R11 reset pin wakes");
    chk(buf_clear, 1, "R11 clear strobe");
    rst_pin_n = 1'b1;
    sleep_req = 1'b0;
    step();
    chk(clkout_gate, 1, "R11 gate with kept code");
    sleep_req = 1'b1;
    step(105);
    chk(state_o, S_ID, "R11 kept code delay early");
    step();
    chk(state_o, S_SL, "R11 kept code delay");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule